// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block takes a reference clock and produces a slower clock whose period is k + 0.5 reference periods, where k is a small integer supplied on an input. A single flip-flop domain cannot do this, because half of the output edges must land on falling reference edges. Instead, a counter runs at the odd integer ratio 2k + 1. Two toggle flops, one clocked on the rising edge and one on the falling edge, each switch twice per counter cycle and so run at f/(2k + 1). The divided clock is the XOR of the two toggle flops. It has two full output periods in every counter cycle.

The counter state selects the moment each toggle flop switches, and this fixes both the phase and the duty of the output. The output is high for k + 1 half reference periods and low for k half reference periods. Its rising edges fall alternately on rising and falling reference edges. The ratio input is expected to stay stable while the block is out of reset. To change the ratio, the block is reset.

Top module: `halfint_clk_div`

## Requirements
- R1: The spacing between consecutive rising edges of `clk_out` is exactly k + 0.5 periods of `clk_in`, for every k from 1 to 7.
- R2: Each high phase of `clk_out` lasts k + 1 half periods of `clk_in`, and each low phase lasts k half periods.
- R3: The first rising edge of `clk_out` after reset coincides with the first rising `clk_in` edge at which `rst_n` is sampled high. From that edge on, the output is periodic with no settling cycles.
- R4: Once `rst_n` has been sampled low at a rising `clk_in` edge, `clk_out` is low by the following rising edge and stays low while `rst_n` remains low.
- R5: A ratio input `half_k` of 0 behaves exactly like a value of 1, giving a period of 1.5 input periods.
- R6: Rising edges of `clk_out` alternate between rising and falling edges of `clk_in`. The first one is on a rising edge.
- R7: Over eight consecutive output periods, the mean period equals k + 0.5 input periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock; both of its edges are used |
| rst_n | input | 1 | Synchronous reset, active low, sampled on rising `clk_in` |
| half_k | input | KW | Integer part k of the ratio k + 0.5; 0 is treated as 1 |
| clk_out | output | 1 | Divided clock with period k + 0.5 reference periods |

## Verification
A wrong counter value or a toggle flop in the wrong state shows up as a wrong output edge time within the first output period after reset, because the first rise is pinned to a known reference edge. If a toggle flop is inverted, the duty cycle flips, and this is visible in the first high phase. If the counter has a wrong wrap point, the rise-to-rise spacing is wrong within one counter cycle, which is at most 2k + 1 reference periods. The bench sweeps every ratio, records every output edge time, and compares each one with the arithmetic expectation.

// File: rtl/halfdiv_pkg.sv
`timescale 1ns/1ps
// Package: halfdiv_pkg
// Shared types and the event-timing arithmetic of the half-integer divider.
// Assumes times are counted in half periods of the reference clock, starting
// at the rising edge that opens counter state 0.
package halfdiv_pkg;

    // Which reference edge a toggle stage is clocked on.
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;

    // Four output transitions per counter cycle: rise, fall, rise, fall.
    localparam int unsigned NUM_EVT = 4;

    // Half-period time of output transition idx for integer part k.
    // A time past one full counter cycle wraps into the next cycle.
    function automatic int unsigned evt_half(input int unsigned idx,
                                             input int unsigned k);
        int unsigned t;
        int unsigned span;
        span = 4 * k + 2;
        case (idx)
            0:       t = 2;
            1:       t = k + 3;
            2:       t = 2 * k + 3;
            default: t = 3 * k + 4;
        endcase
        if (t > span) t = t - span;
        return t;
    endfunction

endpackage

// File: rtl/hid_mod_counter.sv
`timescale 1ns/1ps
// Module: hid_mod_counter
// Counts 0..last on rising clk and wraps to 0; this is the odd integer
// divider at the base of the block. Assumes last is stable outside reset.
module hid_mod_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] count
);

    // Advance the count, wrapping after the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (count >= last) count <= '0;
        else count <= count + 1'b1;
    end

    // R1: the counter stays inside its cycle.
    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= last);

    // R1: the terminal value is followed by zero.
    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == last) |=> (count == '0));

    // R1: below the terminal value the count steps by one.
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count < last) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/hid_event_decode.sv
`timescale 1ns/1ps
// Module: hid_event_decode
// Decides, from the counter state, when each toggle stage must switch.
// Even event times go to the rising-edge stage, odd ones to the
// falling-edge stage. Assumes k_eff is between 1 and 2**KW-1.
module hid_event_decode #(
    parameter int KW = 3,
    parameter int CW = KW + 1
) (
    input  logic [KW-1:0] k_eff,
    input  logic [CW-1:0] count,
    output logic          tog_rise,
    output logic          tog_fall
);
    import halfdiv_pkg::*;

    logic [NUM_EVT-1:0] hit_rise;
    logic [NUM_EVT-1:0] hit_fall;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        int unsigned t_half;
        logic [CW-1:0] slot_rise;
        logic [CW-1:0] slot_fall;
        // Map one output transition onto a counter slot and an edge.
        always_comb begin
            t_half    = evt_half(i, int'(k_eff));
            slot_rise = CW'((t_half >> 1) - 1);
            slot_fall = CW'(t_half >> 1);
            hit_rise[i] = (t_half[0] == 1'b0) && (count == slot_rise);
            hit_fall[i] = (t_half[0] == 1'b1) && (count == slot_fall);
        end
    end

    assign tog_rise = |hit_rise;
    assign tog_fall = |hit_fall;

endmodule

// File: rtl/hid_toggle_stage.sv
`timescale 1ns/1ps
// Module: hid_toggle_stage
// One toggle flop on the edge chosen by EDGE; flips when tog is high.
// Reset is synchronous to the chosen edge and active low.
module hid_toggle_stage #(
    parameter halfdiv_pkg::edge_sel_e EDGE = halfdiv_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog,
    output logic q
);

    if (EDGE == halfdiv_pkg::EDGE_FALL) begin : g_fall
        // Toggle on the falling reference edge.
        always_ff @(negedge clk) begin
            if (!rst_n) q <= 1'b0;
            else if (tog) q <= ~q;
        end
    end else begin : g_rise
        // Toggle on the rising reference edge.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else if (tog) q <= ~q;
        end
    end

endmodule

// File: rtl/halfint_clk_div.sv
`timescale 1ns/1ps
// Module: halfint_clk_div
// Divides clk_in by half_k + 0.5. An odd counter (2k+1 states) drives a
// rising-edge and a falling-edge toggle flop; their XOR is the output.
// Assumes half_k changes only while rst_n is low.
module halfint_clk_div #(
    parameter int KW = 3
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic [KW-1:0] half_k,
    output logic          clk_out
);
    import halfdiv_pkg::*;

    localparam int CW = KW + 1;

    logic [KW-1:0] k_eff;
    logic [CW-1:0] last;
    logic [CW-1:0] cnt;
    logic          live_q;
    logic          tog_rise;
    logic          tog_fall;
    logic          rise_q;
    logic          fall_q;

    assign k_eff = (half_k == '0) ? KW'(1) : half_k;
    assign last  = {k_eff, 1'b0};

    // Marks that the rising-edge domain has left reset; it resets the falling stage.
    always_ff @(posedge clk_in) begin
        if (!rst_n) live_q <= 1'b0;
        else live_q <= 1'b1;
    end

    hid_mod_counter #(.CW(CW)) u_cnt (
        .clk   (clk_in),
        .rst_n (rst_n),
        .last  (last),
        .count (cnt)
    );

    hid_event_decode #(.KW(KW), .CW(CW)) u_dec (
        .k_eff    (k_eff),
        .count    (cnt),
        .tog_rise (tog_rise),
        .tog_fall (tog_fall)
    );

    hid_toggle_stage #(.EDGE(EDGE_RISE)) u_rise (
        .clk   (clk_in),
        .rst_n (rst_n),
        .tog   (tog_rise),
        .q     (rise_q)
    );

    hid_toggle_stage #(.EDGE(EDGE_FALL)) u_fall (
        .clk   (clk_in),
        .rst_n (live_q),
        .tog   (tog_fall),
        .q     (fall_q)
    );

    assign clk_out = rise_q ^ fall_q;

    // R4: reset drives the output low by the next rising edge.
    assert_low_in_reset_R4: assert property (@(posedge clk_in)
        !rst_n |=> !clk_out);

    // R3: leaving counter state 0 always opens a high phase.
    assert_rise_after_zero_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (cnt == '0) |=> clk_out);

endmodule

// File: tb/halfint_clk_div_test.sv
`timescale 1ns/1ps
module halfint_clk_div_test;

    localparam real TCLK = 4.0;
    localparam real EPS  = 0.01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] half_k = 3'd1;
    logic       clk_out;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  cap_en = 1'b0;
    int  nr = 0;
    int  nf = 0;
    real rise_t [16];
    real fall_t [16];

    halfint_clk_div #(.KW(3)) uut (
        .clk_in  (clk),
        .rst_n   (rst_n),
        .half_k  (half_k),
        .clk_out (clk_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk_out) if (cap_en && nr < 16) begin
        rise_t[nr] = $realtime;
        nr = nr + 1;
    end

    always @(negedge clk_out) if (cap_en && nf < 16) begin
        fall_t[nf] = $realtime;
        nf = nf + 1;
    end

    task automatic chk(input string tag, input real act, input real exp);
        real d;
        checks = checks + 1;
        d = act - exp;
        if (d < 0.0) d = -d;
        if (d > EPS) begin
            failures = failures + 1;
            $display("FAIL %s k=%0d actual=%0.3f expected=%0.3f", tag, half_k, act, exp);
        end
    endtask

    task automatic run_k(input int kv);
        int  ke;
        real t0;
        real per;
        real ph;
        ke  = (kv == 0) ? 1 : kv;
        per = (2.0 * ke + 1.0) * TCLK / 2.0;
        rst_n = 1'b0;
        @(posedge clk);
        #1 half_k = 3'(kv);
        repeat (3) @(posedge clk);
        #1;
        chk("R4 reset low", real'(clk_out), 0.0);
        nr = 0;
        nf = 0;
        cap_en = 1'b1;
        rst_n = 1'b1;
        @(posedge clk);
        t0 = $realtime;
        repeat ((2 * ke + 1) * 11 + 4) @(posedge clk);
        #1 cap_en = 1'b0;
        chk("R1 rise count", real'(nr >= 10), 1.0);
        if (nr >= 10 && nf >= 10) begin
            chk("R3 first rise", rise_t[0], t0);
            for (int j = 1; j < 10; j++)
                chk("R1 spacing", rise_t[j] - rise_t[j-1], per);
            for (int j = 0; j < 10; j++)
                chk("R2 high time", fall_t[j] - rise_t[j], (ke + 1) * TCLK / 2.0);
            for (int j = 0; j < 9; j++)
                chk("R2 low time", rise_t[j+1] - fall_t[j], ke * TCLK / 2.0);
            for (int j = 0; j < 10; j++) begin
                ph = (rise_t[j] - t0) - TCLK * $floor((rise_t[j] - t0) / TCLK);
                chk("R6 edge phase", ph, (j % 2) * TCLK / 2.0);
            end
            chk("R7 mean period", (rise_t[8] - rise_t[0]) / 8.0, (ke + 0.5) * TCLK);
            if (kv == 0)
                chk("R5 zero as one", rise_t[1] - rise_t[0], 1.5 * TCLK);
        end
        // Reset in mid-run: wait until the output is high, then reset.
        @(posedge clk_out);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R4 mid-run reset", real'(clk_out), 0.0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R4 initial reset", real'(clk_out), 0.0);
        for (int kv = 0; kv < 8; kv++) run_k(kv);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule